// File: doc/BRIEF.md
# Double-Edge Byte Link Word Receiver

This block sits on the receive side of a source-clocked, byte-wide link. The far end sends a byte on every rising edge and on every falling edge of its link clock. The block captures the byte on each edge. It retimes the falling-edge byte into the rising-edge domain and delays the rising-edge byte by one stage, so that each link cycle yields one aligned byte pair. It then packs the pairs into 32-bit words, lowest byte first.

Each completed word goes to an external receive buffer as a one-cycle write strobe with the word beside it. A second flag marks every fourth word, which closes one 128-bit transfer unit. An enable from an outside handshake controller gates the capture. While the enable is low, nothing is written and the packing position returns to a word boundary.

All registers run on the incoming link clock.

Top module: `ddr_word_rx`

## Requirements
- R1: A byte is sampled on each rising edge and on each falling edge of `lclk`. The rising-edge byte of a cycle is the earlier of the pair, and the falling-edge byte is the later.
- R2: Bytes are packed least significant first: the first byte of a word occupies bits 7:0, the second 15:8, the third 23:16 and the fourth 31:24.
- R3: Latency: the word whose last rising-edge byte is sampled at rising edge k is on `wr_word`, with `wr_vld` high, in the cycle that follows rising edge k+2.
- R4: `wr_vld` is high for exactly one cycle per word. During continuous enable it is high every second cycle, which is half the link clock rate.
- R5: A byte pair whose rising-edge sample saw `lrx_en` low never contributes to a word, and no strobe results from it.
- R6: A low sample of `lrx_en` returns the packing position to the start of a word. A partly assembled word is dropped, and no strobe is raised for it.
- R7: `quad_done` is high together with `wr_vld` on the 4th, 8th, 12th and later words counted from the start of an enabled run, and is low at all other times.
- R8: While reset is asserted, and after it is released, `wr_vld` and `quad_done` are low and `wr_word` is zero until a word completes.
- R9: The enabled byte stream 0x1F, 0x20, up to 0x3E (32 bytes) yields eight words. The first is 0x2221201F, the last is 0x3E3D3C3B, and the fourth and eighth words raise `quad_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lclk | input | 1 | Incoming link clock; clocks all registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| lrx_en | input | 1 | Receive enable from the handshake controller, sampled on rising edges |
| ldat | input | 8 | Link data, new byte on each edge |
| wr_word | output | 32 | Assembled word for the receive buffer |
| wr_vld | output | 1 | One-cycle write strobe for `wr_word` |
| quad_done | output | 1 | High with the strobe of each fourth word in a run |

## Verification
The assertions assume two things about the inputs. `ldat` and `lrx_en` are stable around the edges that sample them, and `lrx_en` changes only relative to rising edges. The bench meets both conditions by driving the rising-edge byte and the enable just after each falling edge, and the falling-edge byte just after each rising edge. Its stimulus covers three cases: an enable pulse too short to finish a word, an enable that drops halfway through a word, and a long run that crosses several transfer units. A behavioural queue model is compared with the outputs in every cycle.

// File: rtl/ddr_rx_pkg.sv
package ddr_rx_pkg;
   localparam int unsigned DEF_BYTE_W   = 8;
   localparam int unsigned DEF_WORD_BY  = 4;
   localparam int unsigned DEF_UNIT_WDS = 4;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/ddr_edge_capture.sv
module ddr_edge_capture
   import ddr_rx_pkg::*;
#(
   parameter int unsigned BYTE_W = DEF_BYTE_W
) (
   input  logic              lclk,
   input  logic              rst_n,
   input  logic              en_in,
   input  logic [BYTE_W-1:0] din,
   output logic [2*BYTE_W-1:0] pair,
   output logic              pair_ok
);
   logic [BYTE_W-1:0] rise_q, rise_d, fall_q, fall_rt;
   logic              en_q, en_d;

   // rising-edge path: capture, then one extra stage to match the falling path
   always_ff @(posedge lclk or negedge rst_n) begin
      if (!rst_n) begin
         rise_q  <= '0;
         rise_d  <= '0;
         fall_rt <= '0;
         en_q    <= 1'b0;
         en_d    <= 1'b0;
      end else begin
         rise_q  <= din;
         rise_d  <= rise_q;
         fall_rt <= fall_q;
         en_q    <= en_in;
         en_d    <= en_q;
      end
   end

   // falling-edge path: its retimed copy lags by one link cycle
   always_ff @(negedge lclk or negedge rst_n) begin
      if (!rst_n) fall_q <= '0;
      else        fall_q <= din;
   end

   assign pair    = {fall_rt, rise_d};
   assign pair_ok = en_d;
endmodule

// File: rtl/ddr_word_packer.sv
module ddr_word_packer
   import ddr_rx_pkg::*;
#(
   parameter int unsigned BYTE_W  = DEF_BYTE_W,
   parameter int unsigned WORD_BY = DEF_WORD_BY
) (
   input  logic                      lclk,
   input  logic                      rst_n,
   input  logic [2*BYTE_W-1:0]       pair,
   input  logic                      pair_ok,
   output logic [BYTE_W*WORD_BY-1:0] word,
   output logic                      word_vld,
   output logic                      word_fire
);
   localparam int unsigned PAIR_W = 2 * BYTE_W;
   localparam int unsigned PAIRS  = WORD_BY / 2;
   localparam int unsigned ACC_N  = PAIRS - 1;
   localparam int unsigned CNT_W  = cnt_width(PAIRS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PAIRS - 1);

   generate
      if (WORD_BY < 4 || (WORD_BY % 2) != 0) begin : g_bad_word
         $error("WORD_BY must be even and at least 4");
      end
   endgenerate

   logic [CNT_W-1:0]            pos;
   logic [PAIR_W-1:0]           acc [ACC_N];
   logic [BYTE_W*WORD_BY-1:0]   word_next;

   assign word_fire = pair_ok && (pos == LAST);

   generate
      for (genvar p = 0; p < PAIRS; p++) begin : g_slot
         if (p == PAIRS - 1) begin : g_top
            assign word_next[p*PAIR_W +: PAIR_W] = pair;
         end else begin : g_low
            assign word_next[p*PAIR_W +: PAIR_W] = acc[p];
            always_ff @(posedge lclk or negedge rst_n) begin
               if (!rst_n)                                  acc[p] <= '0;
               else if (pair_ok && pos == CNT_W'(p))        acc[p] <= pair;
            end
         end
      end
   endgenerate

   always_ff @(posedge lclk or negedge rst_n) begin
      if (!rst_n) begin
         pos      <= '0;
         word     <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= word_fire;
         if (!pair_ok) begin
            pos <= '0;
         end else if (pos == LAST) begin
            pos  <= '0;
            word <= word_next;
         end else begin
            pos <= pos + 1'b1;
         end
      end
   end

   AST_VLD_GAP: assert property (@(posedge lclk) disable iff (!rst_n)
      word_vld |=> !word_vld); // R4
   AST_NO_WRITE_OFF: assert property (@(posedge lclk) disable iff (!rst_n)
      !pair_ok |=> !word_vld); // R5
   AST_FRESH_RUN_NO_WORD: assert property (@(posedge lclk) disable iff (!rst_n)
      $rose(pair_ok) |=> !word_vld); // R6
endmodule

// File: rtl/ddr_unit_tracker.sv
module ddr_unit_tracker
   import ddr_rx_pkg::*;
#(
   parameter int unsigned UNIT_WDS = DEF_UNIT_WDS
) (
   input  logic lclk,
   input  logic rst_n,
   input  logic run,
   input  logic fire,
   output logic unit_done
);
   localparam int unsigned CW = cnt_width(UNIT_WDS);
   localparam logic [CW-1:0] LASTW = CW'(UNIT_WDS - 1);

   generate
      if (UNIT_WDS < 2) begin : g_bad_unit
         $error("UNIT_WDS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] wcnt;

   always_ff @(posedge lclk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt      <= '0;
         unit_done <= 1'b0;
      end else begin
         unit_done <= fire && (wcnt == LASTW);
         if (!run)                wcnt <= '0;
         else if (fire)           wcnt <= (wcnt == LASTW) ? '0 : wcnt + 1'b1;
      end
   end

   AST_UNIT_NEEDS_FIRE: assert property (@(posedge lclk) disable iff (!rst_n)
      unit_done |-> $past(fire)); // R7
endmodule

// File: rtl/ddr_word_rx.sv
module ddr_word_rx
   import ddr_rx_pkg::*;
#(
   parameter int unsigned BYTE_W   = DEF_BYTE_W,
   parameter int unsigned WORD_BY  = DEF_WORD_BY,
   parameter int unsigned UNIT_WDS = DEF_UNIT_WDS
) (
   input  logic                      lclk,
   input  logic                      rst_n,
   input  logic                      lrx_en,
   input  logic [BYTE_W-1:0]         ldat,
   output logic [BYTE_W*WORD_BY-1:0] wr_word,
   output logic                      wr_vld,
   output logic                      quad_done
);
   logic [2*BYTE_W-1:0] pair;
   logic                pair_ok;
   logic                fire;

   ddr_edge_capture #(.BYTE_W(BYTE_W)) u_cap (
      .lclk(lclk), .rst_n(rst_n), .en_in(lrx_en), .din(ldat),
      .pair(pair), .pair_ok(pair_ok)
   );

   ddr_word_packer #(.BYTE_W(BYTE_W), .WORD_BY(WORD_BY)) u_pack (
      .lclk(lclk), .rst_n(rst_n), .pair(pair), .pair_ok(pair_ok),
      .word(wr_word), .word_vld(wr_vld), .word_fire(fire)
   );

   ddr_unit_tracker #(.UNIT_WDS(UNIT_WDS)) u_unit (
      .lclk(lclk), .rst_n(rst_n), .run(pair_ok), .fire(fire),
      .unit_done(quad_done)
   );

   AST_QUAD_WITH_VLD: assert property (@(posedge lclk) disable iff (!rst_n)
      quad_done |-> wr_vld); // R7
   AST_RESET_QUIET: assert property (@(posedge lclk)
      !rst_n |-> (!wr_vld && !quad_done)); // R8
endmodule

// File: tb/tb_ddr_word_rx.sv
module tb_ddr_word_rx;
   localparam int CLK_P = 10;

   logic        lclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lrx_en = 1'b0;
   logic [7:0]  ldat = 8'h00;
   logic [31:0] wr_word;
   logic        wr_vld;
   logic        quad_done;

   int n_chk = 0;
   int n_bad = 0;
   int n = 0;
   bit done = 0;

   bit         he[$];
   logic [7:0] ha[$];
   logic [7:0] hb[$];
   logic [7:0] mq[$];
   int         mw = 0;
   logic [31:0] got[$];
   bit          gotq[$];
   bit          capture = 0;

   ddr_word_rx dut (
      .lclk(lclk), .rst_n(rst_n), .lrx_en(lrx_en), .ldat(ldat),
      .wr_word(wr_word), .wr_vld(wr_vld), .quad_done(quad_done)
   );

   always #(CLK_P/2) lclk = ~lclk;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s cycle %0d: actual %h expected %h", req, n, act, exp);
      end
   endtask

   // behavioural model: pair n-2 shows at the outputs after rising edge n
   task automatic step(bit e, logic [7:0] a, logic [7:0] b);
      bit          ev, eq;
      logic [31:0] ew;
      @(negedge lclk); #1;
      lrx_en = e; ldat = a;
      he.push_back(e); ha.push_back(a); hb.push_back(b);
      @(posedge lclk); #1;
      ldat = b;
      #1;
      ev = 0; eq = 0; ew = '0;
      if (n >= 2) begin
         if (!he[n-2]) begin
            mq.delete(); mw = 0;
         end else begin
            mq.push_back(ha[n-2]); mq.push_back(hb[n-2]);
            if (mq.size() == 4) begin
               ew = {mq[3], mq[2], mq[1], mq[0]};
               ev = 1; mw++;
               eq = (mw % 4 == 0);
               mq.delete();
            end
         end
      end
      chk("R4/R5/R6 wr_vld", {31'd0, wr_vld}, {31'd0, ev});
      chk("R7 quad_done", {31'd0, quad_done}, {31'd0, eq});
      if (ev) chk("R1/R2/R3 wr_word", wr_word, ew);
      if (capture && wr_vld) begin
         got.push_back(wr_word); gotq.push_back(quad_done);
      end
      n++;
   endtask

   task automatic idle(int k);
      for (int i = 0; i < k; i++) step(0, 8'hA5, 8'h5A);
   endtask

   initial begin
      #(CLK_P*200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] seed;
      repeat (3) @(posedge lclk);
      #2;
      // R8: quiet during reset
      chk("R8 wr_vld in reset", {31'd0, wr_vld}, 32'd0);
      chk("R8 word in reset", wr_word, 32'd0);
      @(negedge lclk); rst_n = 1'b1;
      #1;
      chk("R8 quad after reset", {31'd0, quad_done}, 32'd0);

      // R9: worked example, 32 bytes 0x1F..0x3E
      idle(2);
      capture = 1;
      for (int i = 0; i < 16; i++) step(1, 8'(8'h1F + 2*i), 8'(8'h20 + 2*i));
      idle(3);
      capture = 0;
      chk("R9 word count", got.size(), 32'd8);
      if (got.size() == 8) begin
         chk("R9 first word", got[0], 32'h2221201F);
         chk("R9 last word", got[7], 32'h3E3D3C3B);
         chk("R9 quad on 4th", {31'd0, gotq[3]}, 32'd1);
         chk("R9 quad on 8th", {31'd0, gotq[7]}, 32'd1);
      end

      // R5: data toggling with enable low, no writes
      for (int i = 0; i < 6; i++) step(0, 8'(i*17), 8'(i*29));
      // R6: enable for one pair only, then mid-word drop
      step(1, 8'h11, 8'h22);
      idle(3);
      for (int i = 0; i < 3; i++) step(1, 8'(8'h40 + i), 8'(8'h80 + i));
      idle(3);
      // R6: back-to-back runs split by one low cycle
      for (int i = 0; i < 5; i++) step(1, 8'(8'hC0 + i), 8'(8'hD0 + i));
      step(0, 8'hEE, 8'hEE);
      for (int i = 0; i < 4; i++) step(1, 8'(8'h60 + i), 8'(8'h70 + i));
      idle(3);

      // R7/R4: long run over several units
      seed = 8'h3B;
      for (int i = 0; i < 40; i++) begin
         logic [7:0] a, b;
         seed = 8'(seed * 8'd13 + 8'd7); a = seed;
         seed = 8'(seed * 8'd13 + 8'd7); b = seed;
         step(1, a, b);
      end
      idle(4);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule